// File: doc/BRIEF.md
# Video line and frame sequencer

This block derives the horizontal and vertical rhythm of a video raster from the system clock. It supports two standards: a 60 Hz standard of 263 lines per frame and a 50 Hz standard of 313 lines per frame. Each line period comes from a fixed-point accumulator with 12 fraction bits. On every line the accumulator adds a per-standard increment. The integer part of the sum sets that line's length in clocks, and the fraction is kept for the next line. Over many lines the average line length therefore matches the clock rate exactly.

A line counter tracks the position in the frame. It raises a one-clock vertical-blank interrupt on the blanking line and wraps at the end of the frame. At each wrap a frame parity bit toggles. When interlace is enabled, this parity drives an externally visible field bit. A status flag marks the blanking period of progressive frames. A separate strobe fires every fixed number of lines so that an audio engine can be paced.

The frame control is a two-state machine. PH_ACTIVE covers the visible lines. The transition *enter_blank* (the line pulse that brings the count to the blanking line) moves it to PH_BLANK and issues the interrupt. The transition *frame_wrap* (the line pulse that completes the frame) returns it to PH_ACTIVE and clears the counter.

Top module: `video_frame_seq`

## Requirements
- R1: Reset state and first line.
  - While reset is high, every output is low and the standard is the 60 Hz one.
  - After reset, the frame count is 0, the line count is 0 and the audio count is 0.
  - The first line lasts INC_60 >> 12 clocks.
- R2: line_pulse is high for exactly one clock, the last clock of each line period.
- R3: Line length.
  - A line lasts floor((frac + inc) / 4096) clocks, where frac is the 12-bit fraction carried from the previous line.
  - The new fraction is (frac + inc) mod 4096.
  - inc is 8791293 for the 60 Hz standard and 8864320 for the 50 Hz standard.
- R4: Blanking interrupt.
  - vblank_irq is high for one clock, the clock after the line pulse that makes the frame's line count equal 240 (60 Hz) or 256 (50 Hz).
  - std_sel = 0 selects 60 Hz and std_sel = 1 selects 50 Hz.
- R5: Frame wrap.
  - The line pulse that makes the line count equal 263 (60 Hz) or 313 (50 Hz) ends the frame.
  - The line count returns to 0 and the frame count increments.
- R6: Field bit.
  - At each frame wrap, field_bit becomes the low bit of the incremented frame count if ilace_en is high, and 0 otherwise.
  - field_bit changes at no other time.
- R7: Status flag.
  - lace_flag is set together with vblank_irq only if ilace_en is low on that line pulse.
  - lace_flag is cleared in the clock after each frame wrap.
- R8: Audio strobe.
  - audio_strobe is high for one clock after every 32nd line pulse.
  - The count runs across frame boundaries and restarts after each strobe.
- R9: Standard select.
  - std_sel is sampled only on the line pulse that completes a frame.
  - The sampled value governs the whole next frame, starting with the length of its first line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| std_sel | input | 1 | Requested standard: 0 = 60 Hz, 1 = 50 Hz |
| ilace_en | input | 1 | Interlace enable |
| line_pulse | output | 1 | High on the last clock of each line |
| vblank_irq | output | 1 | One-clock blanking interrupt |
| field_bit | output | 1 | Interlace field |
| lace_flag | output | 1 | Progressive blanking status flag |
| audio_strobe | output | 1 | One-clock audio pacing strobe |

## Verification
The bench runs the sequencer with small line counts and increments, so that many frames fit in a short run. It compares every output on every clock against a behavioural model.

The fraction carry is a key target. A design that dropped the carry, or truncated the sum before adding the old fraction, would end lines one clock early in some places, and the line pulses would drift against the model.

The bench changes std_sel and ilace_en in the middle of frames. A design that took the standard at once would give a wrong line length or blanking line within the current frame. A design that toggled the field regardless of interlace, or kept the flag set across a wrap, would disagree with the model right after the wrap. The bench also changes the inputs across frame boundaries. An audio counter that restarted at the wrap would strobe at the wrong line.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
    typedef enum logic {
        STD_60 = 1'b0,
        STD_50 = 1'b1
    } std_t;

    typedef enum logic {
        PH_ACTIVE = 1'b0,
        PH_BLANK  = 1'b1
    } phase_t;
endpackage

// File: rtl/vfs_line_timer.sv
module vfs_line_timer
    import vfs_pkg::*;
#(
    parameter int FRAC_W = 12,
    parameter int INC_60 = 8791293,
    parameter int INC_50 = 8864320
) (
    input  logic clk,
    input  logic rst,
    input  std_t std_next,
    output logic line_end
);
    localparam int SUM_W = 32;
    localparam int PER_W = SUM_W - FRAC_W;
    localparam logic [SUM_W-1:0] INC60_V = SUM_W'(INC_60);
    localparam logic [SUM_W-1:0] INC50_V = SUM_W'(INC_50);
    localparam logic [PER_W-1:0] FIRST_LEFT = INC60_V[SUM_W-1:FRAC_W] - PER_W'(1);

    logic [FRAC_W-1:0] frac_q;
    logic [PER_W-1:0]  left_q;
    logic [SUM_W-1:0]  sum;

    always_comb begin
        sum = {{PER_W{1'b0}}, frac_q} + ((std_next == STD_50) ? INC50_V : INC60_V);
    end

    assign line_end = (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            frac_q <= INC60_V[FRAC_W-1:0];
            left_q <= FIRST_LEFT;
        end else if (line_end) begin
            frac_q <= sum[FRAC_W-1:0];
            left_q <= sum[SUM_W-1:FRAC_W] - PER_W'(1);
        end else begin
            left_q <= left_q - PER_W'(1);
        end
    end

    // R2: a line is never a single clock, so the pulse cannot stay high
    a_r2_one_clock: assert property (@(posedge clk) disable iff (rst)
        line_end |=> !line_end);

    // R3: the countdown only moves by one between line ends
    a_r3_countdown: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> (left_q == $past(left_q) - PER_W'(1)));
endmodule

// File: rtl/vfs_frame_fsm.sv
module vfs_frame_fsm
    import vfs_pkg::*;
#(
    parameter int LINES_60 = 263,
    parameter int LINES_50 = 313,
    parameter int VBL_60   = 240,
    parameter int VBL_50   = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic line_end,
    input  logic std_sel,
    input  logic ilace_en,
    output std_t std_next,
    output logic vblank_irq,
    output logic field_bit,
    output logic lace_flag
);
    localparam int MAX_LINES = (LINES_60 > LINES_50) ? LINES_60 : LINES_50;
    localparam int LINE_W    = $clog2(MAX_LINES + 1);

    std_t              std_q;
    phase_t            phase_q, phase_d;
    logic [LINE_W-1:0] line_q, line_nx, lines_tot, vbl_at;
    logic              par_q;
    logic              wrap, enter_blank;

    always_comb begin
        lines_tot = (std_q == STD_50) ? LINE_W'(LINES_50) : LINE_W'(LINES_60);
        vbl_at    = (std_q == STD_50) ? LINE_W'(VBL_50)   : LINE_W'(VBL_60);
        line_nx   = line_q + LINE_W'(1);
        wrap      = line_end && (line_nx == lines_tot);
        std_next  = wrap ? std_t'(std_sel) : std_q;
    end

    // next-state logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_ACTIVE: if (line_end && line_nx == vbl_at) phase_d = PH_BLANK;
            PH_BLANK:  if (wrap)                          phase_d = PH_ACTIVE;
            default:   phase_d = PH_ACTIVE;
        endcase
    end

    assign enter_blank = (phase_q == PH_ACTIVE) && (phase_d == PH_BLANK);

    // state register
    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_ACTIVE;
        else     phase_q <= phase_d;
    end

    // counters and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            std_q      <= STD_60;
            line_q     <= '0;
            par_q      <= 1'b0;
            vblank_irq <= 1'b0;
            field_bit  <= 1'b0;
            lace_flag  <= 1'b0;
        end else begin
            vblank_irq <= 1'b0;
            if (enter_blank) begin
                vblank_irq <= 1'b1;
                if (!ilace_en) lace_flag <= 1'b1;
            end
            if (wrap) begin
                line_q    <= '0;
                par_q     <= ~par_q;
                field_bit <= ilace_en ? ~par_q : 1'b0;
                lace_flag <= 1'b0;
                std_q     <= std_next;
            end else if (line_end) begin
                line_q <= line_nx;
            end
        end
    end

    a_r4_irq_one_clock: assert property (@(posedge clk) disable iff (rst)
        vblank_irq |=> !vblank_irq);
    a_r4_irq_after_line: assert property (@(posedge clk) disable iff (rst)
        vblank_irq |-> $past(line_end));
    a_r5_line_bound: assert property (@(posedge clk) disable iff (rst)
        line_q < lines_tot);
    a_r6_field_at_wrap: assert property (@(posedge clk) disable iff (rst)
        !$stable(field_bit) |-> $past(wrap));
    a_r7_flag_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(lace_flag) |-> vblank_irq);
    a_r9_std_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(std_q) |-> $past(wrap));
endmodule

// File: rtl/vfs_audio_tick.sv
module vfs_audio_tick #(
    parameter int AUD_LINES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic line_end,
    output logic audio_strobe
);
    localparam int AUD_W = (AUD_LINES > 2) ? $clog2(AUD_LINES) : 1;
    localparam logic [AUD_W-1:0] LAST = AUD_W'(AUD_LINES - 1);

    logic [AUD_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q        <= '0;
            audio_strobe <= 1'b0;
        end else begin
            audio_strobe <= 1'b0;
            if (line_end) begin
                if (cnt_q == LAST) begin
                    cnt_q        <= '0;
                    audio_strobe <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + AUD_W'(1);
                end
            end
        end
    end

    a_r8_strobe_after_line: assert property (@(posedge clk) disable iff (rst)
        audio_strobe |-> $past(line_end));
    a_r8_strobe_one_clock: assert property (@(posedge clk) disable iff (rst)
        audio_strobe |=> !audio_strobe);
endmodule

// File: rtl/video_frame_seq.sv
module video_frame_seq
    import vfs_pkg::*;
#(
    parameter int FRAC_W    = 12,
    parameter int INC_60    = 8791293,
    parameter int INC_50    = 8864320,
    parameter int LINES_60  = 263,
    parameter int LINES_50  = 313,
    parameter int VBL_60    = 240,
    parameter int VBL_50    = 256,
    parameter int AUD_LINES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic std_sel,
    input  logic ilace_en,
    output logic line_pulse,
    output logic vblank_irq,
    output logic field_bit,
    output logic lace_flag,
    output logic audio_strobe
);
    std_t std_next;

    vfs_line_timer #(
        .FRAC_W (FRAC_W),
        .INC_60 (INC_60),
        .INC_50 (INC_50)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .std_next (std_next),
        .line_end (line_pulse)
    );

    vfs_frame_fsm #(
        .LINES_60 (LINES_60),
        .LINES_50 (LINES_50),
        .VBL_60   (VBL_60),
        .VBL_50   (VBL_50)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .line_end   (line_pulse),
        .std_sel    (std_sel),
        .ilace_en   (ilace_en),
        .std_next   (std_next),
        .vblank_irq (vblank_irq),
        .field_bit  (field_bit),
        .lace_flag  (lace_flag)
    );

    vfs_audio_tick #(
        .AUD_LINES (AUD_LINES)
    ) u_audio (
        .clk          (clk),
        .rst          (rst),
        .line_end     (line_pulse),
        .audio_strobe (audio_strobe)
    );
endmodule

// File: tb/video_frame_seq_test.sv
module video_frame_seq_test;
    localparam int FB  = 12;
    localparam int IA  = 3 * 4096 + 1365;
    localparam int IB  = 4 * 4096 + 2048;
    localparam int LA  = 13;
    localparam int LB  = 11;
    localparam int VA  = 9;
    localparam int VB  = 7;
    localparam int AUD = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic std_sel = 1'b0;
    logic ilace_en = 1'b0;
    logic line_pulse, vblank_irq, field_bit, lace_flag, audio_strobe;

    video_frame_seq #(
        .FRAC_W(FB), .INC_60(IA), .INC_50(IB), .LINES_60(LA), .LINES_50(LB),
        .VBL_60(VA), .VBL_50(VB), .AUD_LINES(AUD)
    ) uut (
        .clk(clk), .rst(rst), .std_sel(std_sel), .ilace_en(ilace_en),
        .line_pulse(line_pulse), .vblank_irq(vblank_irq), .field_bit(field_bit),
        .lace_flag(lace_flag), .audio_strobe(audio_strobe)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit compare_on = 0;
    string pulse_tag = "R3";

    // behavioural reference
    int m_rem, m_frac, m_line, m_std, m_par, m_aud;
    bit e_irq, e_str, e_field, e_flag;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_rem = IA / 4096; m_frac = IA % 4096; m_line = 0; m_std = 0;
            m_par = 0; m_aud = 0; e_irq = 0; e_str = 0; e_field = 0; e_flag = 0;
        end else begin
            e_irq = 0; e_str = 0;
            if (m_rem == 1) begin
                int s;
                m_line++;
                if (m_line == (m_std ? LB : LA)) begin
                    m_line = 0; m_par ^= 1; e_field = ilace_en ? m_par[0] : 1'b0;
                    e_flag = 0; m_std = std_sel;
                end else if (m_line == (m_std ? VB : VA)) begin
                    e_irq = 1;
                    if (!ilace_en) e_flag = 1;
                end
                m_aud++;
                if (m_aud == AUD) begin m_aud = 0; e_str = 1; end
                s = m_frac + (m_std ? IB : IA);
                m_rem = s / 4096; m_frac = s % 4096;
            end else begin
                m_rem--;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (compare_on && !rst) begin
            chk(line_pulse == (m_rem == 1), {pulse_tag, " line_pulse (R2)"}, line_pulse, m_rem == 1);
            chk(vblank_irq == e_irq, "R4 vblank_irq", vblank_irq, e_irq);
            chk(field_bit == e_field, "R5,R6 field_bit", field_bit, e_field);
            chk(lace_flag == e_flag, "R7 lace_flag", lace_flag, e_flag);
            chk(audio_strobe == e_str, "R8 audio_strobe", audio_strobe, e_str);
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                run(3);
                // R1: reset state
                chk({line_pulse, vblank_irq, field_bit, lace_flag, audio_strobe} == 5'b0,
                    "R1 outputs in reset",
                    {line_pulse, vblank_irq, field_bit, lace_flag, audio_strobe}, 0);
                rst = 1'b0;
                compare_on = 1;
                // R1: first line lasts IA>>12 clocks
                run((IA / 4096) - 1);
                chk(line_pulse == 1'b1, "R1 first line length", line_pulse, 1);
                run(400);
                ilace_en = 1'b1;
                run(300);
                pulse_tag = "R9";
                run(17);
                std_sel = 1'b1;
                run(400);
                ilace_en = 1'b0;
                run(23);
                std_sel = 1'b0;
                run(300);
                ilace_en = 1'b1;
                run(250);
                pulse_tag = "R3";
                rst = 1'b1;
                run(2);
                chk({vblank_irq, field_bit, lace_flag, audio_strobe} == 4'b0,
                    "R1 outputs after second reset",
                    {vblank_irq, field_bit, lace_flag, audio_strobe}, 0);
                rst = 1'b0;
                run(500);
            end
            begin
                run(20000);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule